// File: doc/BRIEF.md
# Stop Mode Wake Controller

This block puts a core into a clock-stopped low-power state and brings it back. Software writes the power-control register with its stop bit set. On the next oscillator clock the controller drops the core clock enable, so every gated clock in the core stops. The controller itself runs on the raw oscillator clock, so its edge detectors keep watching the external interrupt lines while the core is stopped.

A falling edge on any of the wake lines ends the stopped state and starts a warm-up count that gives the crystal time to settle. When the count ends, the controller turns the core clock back on and clears the stop flag by itself. It then raises a one-cycle interrupt request for each line that caused the wake. A reset at any point returns the block to the running state and cancels any warm-up in progress.

The controller has three states. RUN means the core is clocked. STOPPED means the core clock is off and the block is waiting for an edge. WARMUP means the core clock is off and the settling count is running. The transitions are:
- stop-write: RUN to STOPPED.
- wake-edge: STOPPED to WARMUP.
- count-done: WARMUP to RUN.
- reset: any state to RUN.

Top module: `stopw_ctrl`

## Requirements
- R1: After reset the block is in RUN, with `core_clk_en`=1, `stop_flag`=0 and `wake_irq`=0.
- R2: A write with `pcon_addr`=8'h87 and `pcon_wdata` bit 1 = 1, made while in RUN, moves the block to STOPPED on that clock edge. From the next cycle `core_clk_en`=0 and `stop_flag`=1. The other data bits have no effect.
- R3: These writes change nothing: a write to any other address, a write to 8'h87 with bit 1 = 0, and any write made while in STOPPED or WARMUP.
- R4: Each line in `ext_int_n` passes through a two-stage synchronizer. A falling edge seen in STOPPED starts WARMUP, and the block is in WARMUP two clock edges after the edge where the low level is first sampled. The core clock stays off.
- R5: WARMUP lasts exactly WARM_CYCLES oscillator clocks (default 65,536). After that, `core_clk_en`=1 and `stop_flag`=0. The low level is first sampled at edge k, and the enable is first high after edge k+2+WARM_CYCLES.
- R6: In the first cycle after WARMUP ends, `wake_irq` is high for exactly one cycle. Bit i is set for each line i that fell on the edge that started WARMUP, and several lines can be set together.
- R7: These do not start WARMUP and do not raise `wake_irq`: a line that is already low when STOPPED is entered, a line held low, a rising edge, and a falling edge seen in RUN or WARMUP.
- R8: Reset asserted in STOPPED or WARMUP returns the block to RUN with `stop_flag`=0, and no `wake_irq` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Raw oscillator clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcon_wr | input | 1 | Register write strobe |
| pcon_addr | input | 8 | Register write address |
| pcon_wdata | input | 8 | Register write data |
| ext_int_n | input | N_LINES | Active-low external wake lines |
| core_clk_en | output | 1 | Core clock enable, 1 = clocks run |
| stop_flag | output | 1 | Stop bit as seen by software |
| wake_irq | output | N_LINES | One-cycle request per waking line |

## Verification
A stop write shows its effect one cycle after the write edge. A wake line sampled low at edge k puts the block in WARMUP at edge k+2. It releases the clock and pulses `wake_irq` after edge k+2+WARM_CYCLES. The bench drives all inputs on the falling clock edge. A behavioural model that keeps a history queue of pin samples advances on every rising edge, and the bench compares every output with it on every falling edge, so each of these delays is checked at its exact cycle. A separate count of cycles from a pin drive to clock release checks the WARM_CYCLES+3 figure directly.

// File: rtl/stopw_pkg.sv
package stopw_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_WARM = 2'd2
    } stopw_state_e;
endpackage

// File: rtl/stopw_fall_det.sv
// Two-stage synchronizer followed by a falling-edge detector on the raw clock.
module stopw_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    logic sync1;
    logic sync2;
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign fall = prev & ~sync2;

    // R7
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/stopw_warm_ctr.sv
// Settling counter: counts only while enabled, clears when idle or done.
module stopw_warm_ctr #(
    parameter int CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (!run || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/stopw_ctrl.sv
module stopw_ctrl
    import stopw_pkg::*;
#(
    parameter int          N_LINES     = 4,
    parameter int          WARM_CYCLES = 65536,
    parameter logic [7:0]  CFG_ADDR    = 8'h87,
    parameter int          STOP_BIT    = 1
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               pcon_wr,
    input  logic [7:0]         pcon_addr,
    input  logic [7:0]         pcon_wdata,
    input  logic [N_LINES-1:0] ext_int_n,
    output logic               core_clk_en,
    output logic               stop_flag,
    output logic [N_LINES-1:0] wake_irq
);
    stopw_state_e       state, state_nx;
    logic [N_LINES-1:0] fall_vec;
    logic [N_LINES-1:0] wake_src;
    logic               stop_req;
    logic               warm_done;

    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_line
            stopw_fall_det u_det (
                .clk   (osc_clk),
                .rst_n (rst_n),
                .pin_n (ext_int_n[gi]),
                .fall  (fall_vec[gi])
            );
        end
    endgenerate

    stopw_warm_ctr #(.CYCLES(WARM_CYCLES)) u_ctr (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .run   (state == ST_WARM),
        .done  (warm_done)
    );

    assign stop_req = pcon_wr && (pcon_addr == CFG_ADDR) && pcon_wdata[STOP_BIT];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (stop_req)       state_nx = ST_STOP;
            ST_STOP: if (|fall_vec)      state_nx = ST_WARM;
            ST_WARM: if (warm_done)      state_nx = ST_RUN;
            default:                     state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_src <= '0;
            wake_irq <= '0;
        end else begin
            wake_irq <= '0;
            unique case (state)
                ST_STOP: if (|fall_vec) wake_src <= fall_vec;
                ST_WARM: if (warm_done) wake_irq <= wake_src;
                default: ;
            endcase
        end
    end

    assign core_clk_en = (state == ST_RUN);
    assign stop_flag   = (state != ST_RUN);

    // R2
    stop_entry_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req) |=> (stop_flag && !core_clk_en));
    // R7
    run_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state == ST_RUN && !stop_req) |=> (state == ST_RUN && wake_irq == '0));
    // R4
    stop_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state == ST_STOP && fall_vec == '0) |=> (state == ST_STOP));
    // R3
    warm_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (state == ST_WARM && !warm_done) |=> (state == ST_WARM));
    // R6
    irq_at_release_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (wake_irq != '0) |-> (core_clk_en && $past(state) == ST_WARM));
endmodule

// File: tb/tb_stopw_ctrl.sv
module tb_stopw_ctrl;
    localparam int NL   = 4;
    localparam int WARM = 40;

    logic          osc_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          pcon_wr = 1'b0;
    logic [7:0]    pcon_addr = 8'h00;
    logic [7:0]    pcon_wdata = 8'h00;
    logic [NL-1:0] ext_int_n = '1;
    logic          core_clk_en;
    logic          stop_flag;
    logic [NL-1:0] wake_irq;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done_flag = 1'b0;

    always #4 osc_clk = ~osc_clk;

    stopw_ctrl #(.N_LINES(NL), .WARM_CYCLES(WARM)) dut (
        .osc_clk(osc_clk), .rst_n(rst_n), .pcon_wr(pcon_wr),
        .pcon_addr(pcon_addr), .pcon_wdata(pcon_wdata),
        .ext_int_n(ext_int_n), .core_clk_en(core_clk_en),
        .stop_flag(stop_flag), .wake_irq(wake_irq)
    );

    // Behavioural reference: mode 0 running, 1 stopped, 2 settling.
    int            m_mode;
    int            m_cnt;
    logic [NL-1:0] m_mask;
    logic [NL-1:0] m_irq;
    logic [NL-1:0] hist[$];

    always @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_mask = '0; m_irq = '0;
            hist = {'1, '1, '1};
        end else begin
            logic [NL-1:0] fell;
            fell  = hist[2] & ~hist[1];
            m_irq = '0;
            if (m_mode == 0) begin
                if (pcon_wr && pcon_addr == 8'h87 && pcon_wdata[1]) m_mode = 1;
            end else if (m_mode == 1) begin
                if (fell != '0) begin m_mode = 2; m_cnt = 0; m_mask = fell; end
            end else begin
                if (m_cnt == WARM - 1) begin m_mode = 0; m_irq = m_mask; end
                else m_cnt = m_cnt + 1;
            end
            hist.push_front(ext_int_n);
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge osc_clk) begin
        if (!done_flag) begin
            check(cur_req, "core_clk_en", int'(core_clk_en), (m_mode == 0) ? 1 : 0);
            check(cur_req, "stop_flag", int'(stop_flag), (m_mode != 0) ? 1 : 0);
            check(cur_req, "wake_irq", int'(wake_irq), int'(m_irq));
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge osc_clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge osc_clk);
        pcon_wr = 1'b1; pcon_addr = a; pcon_wdata = d;
        @(negedge osc_clk);
        pcon_wr = 1'b0;
    endtask

    task automatic finish_run();
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge osc_clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        // R1: reset state
        cyc(3);
        check("R1", "reset clk_en", int'(core_clk_en), 1);
        check("R1", "reset irq", int'(wake_irq), 0);
        rst_n = 1'b1;
        cyc(4);

        // R3: writes that must not stop the core
        cur_req = "R3";
        wr(8'h86, 8'hFF);
        wr(8'h87, 8'hFD);
        cyc(2);
        check("R3", "still running", int'(core_clk_en), 1);

        // R2: stop entry with other data bits set
        cur_req = "R2";
        wr(8'h87, 8'hF2);
        check("R2", "stopped", int'(stop_flag), 1);
        cur_req = "R3";
        wr(8'h87, 8'h02);
        cyc(5);

        // R4/R5: single-cycle pulse on line 2, measure release latency
        cur_req = "R4";
        @(negedge osc_clk);
        ext_int_n[2] = 1'b0;
        lat = 0;
        @(negedge osc_clk);
        ext_int_n[2] = 1'b1;
        lat = 1;
        cyc(5);
        lat += 5;
        // R7: edge during settling is ignored
        cur_req = "R7";
        ext_int_n[0] = 1'b0;
        @(negedge osc_clk); lat++;
        ext_int_n[0] = 1'b1;
        cur_req = "R5";
        while (!core_clk_en && lat < 500) begin
            @(negedge osc_clk); lat++;
        end
        check("R5", "release latency", lat, WARM + 3);
        check("R6", "irq line 2", int'(wake_irq), 4'b0100);
        cur_req = "R6";
        cyc(1);
        check("R6", "irq one cycle", int'(wake_irq), 0);

        // R7: line held low before stop does not wake
        cur_req = "R7";
        ext_int_n[1] = 1'b0;
        cyc(4);
        wr(8'h87, 8'h02);
        cyc(30);
        ext_int_n[1] = 1'b1;
        cyc(10);
        check("R7", "held low no wake", int'(stop_flag), 1);

        // R6: two lines falling together
        cur_req = "R6";
        ext_int_n[0] = 1'b0; ext_int_n[3] = 1'b0;
        cyc(WARM + 4);
        check("R6", "released", int'(core_clk_en), 1);
        ext_int_n = '1;
        cyc(4);

        // R8: reset during settling
        cur_req = "R8";
        wr(8'h87, 8'h02);
        cyc(3);
        ext_int_n[3] = 1'b0;
        cyc(10);
        #2 rst_n = 1'b0;
        cyc(2);
        check("R8", "reset in settling", int'(stop_flag), 0);
        rst_n = 1'b1;
        ext_int_n[3] = 1'b1;
        cyc(WARM + 5);

        // R8: reset while stopped
        wr(8'h87, 8'h02);
        cyc(5);
        #2 rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(5);
        check("R8", "reset in stop", int'(core_clk_en), 1);

        finish_run();
    end
endmodule